// File: doc/BRIEF.md
# Half-Duplex Collision Jam and Backoff Controller

This controller sits beside the transmit path of a half-duplex Ethernet MAC. It watches the PHY collision indication while the transmitter is active. When a collision arrives, it keeps the transmitter busy with a jam period of a fixed number of bit times. After the jam it either holds the station silent for a pseudo-random number of slot times and then asks for a retry, or it reports a late collision, or it gives up on the frame.

Every input and output is sampled or updated on the rising clock. A one-cycle `bit_tick_i` pulse marks each elapsed bit time, and all durations are counted in those ticks. The transmitter pulses `frame_start_i` when it begins sending a frame, including a frame resent after a retry request. It holds `tx_active_i` high for as long as it is sending.

The controller counts ticks from the start of the frame to decide whether a collision falls inside the slot-time window. It counts consecutive early collisions on the current frame and sizes each backoff with the truncated binary exponential rule. The random values come from a free-running LFSR.

Top module: `csma_col_ctrl`

## Requirements
- R1: While reset is asserted, and directly after it is released, `jam_o`, `backoff_o`, `retry_o`, `late_col_o` and `abort_o` are all low.
- R2: If `col_i` and `tx_active_i` are both high in a cycle of the transmit phase, `jam_o` is high from the next cycle on. It stays high for exactly `JAM_BITS` cycles that carry `bit_tick_i`, and then drops.
- R3: A collision has no effect outside the transmit phase, for example while idle. In the transmit phase a collision also has no effect while `tx_active_i` is low: a low `tx_active_i` there ends the attempt as a success and produces no jam.
- R4: The slot window counts the ticks in the transmit-phase cycles that follow the cycle of an accepted `frame_start_i`. A collision seen after fewer than `SLOT_BITS` counted ticks is early. A collision seen after `SLOT_BITS` or more counted ticks is late.
- R5: A late collision still produces the jam. After the jam the controller goes idle with `late_col_o` high, and with no backoff and no retry. `late_col_o` stays high until the next accepted `frame_start_i`.
- R6: The n-th consecutive early collision, with n below `MAX_ATTEMPTS`, is followed directly after the jam by `backoff_o`. `backoff_o` stays high for r times `SLOT_BITS` ticks, where 0 <= r <= 2^min(n, `BACKOFF_LIMIT`) - 1. When r = 0, the backoff phase is skipped.
- R7: `retry_o` rises when the backoff ends, or right after the jam when r = 0. It stays high until `frame_start_i`, and that frame start keeps the count of attempts.
- R8: The `MAX_ATTEMPTS`-th consecutive early collision ends its jam with a one-cycle pulse on `abort_o` and no backoff or retry. The attempt count is then cleared.
- R9: The attempt count returns to zero when `tx_active_i` falls in the transmit phase without a collision (a success). It also returns to zero on a `frame_start_i` accepted while idle.
- R10: From attempt `BACKOFF_LIMIT` onward, the backoff exponent stays at `BACKOFF_LIMIT`.
- R11: The random source runs freely from a nonzero seed, so a series of backoffs yields more than one distinct slot count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bit_tick_i | input | 1 | One-cycle pulse per bit time |
| col_i | input | 1 | Collision indication from the PHY |
| tx_active_i | input | 1 | Transmitter is sending the frame |
| frame_start_i | input | 1 | Pulse at the start of each transmission attempt |
| jam_o | output | 1 | Jam period in progress |
| backoff_o | output | 1 | Backoff wait in progress |
| retry_o | output | 1 | Retry requested, held until the next frame start |
| late_col_o | output | 1 | The last collision fell outside the slot window |
| abort_o | output | 1 | One-cycle pulse when the attempt limit is reached |

## Verification
The main function is tried with several collision patterns:
- Collisions placed exactly one tick before the window boundary and exactly on it separate early from late handling.
- Jams run under dense and sparse bit ticks, which shows that the jam counts ticks and not cycles.
- A run of sixteen consecutive early collisions exposes the abort and the capping of the exponent.
- Fifteen collisions followed by a success, or by a late collision and a fresh frame, show whether the attempt count is cleared. If it were not, the next collision would abort.
- Collisions while idle, or while `tx_active_i` is low, must leave every output quiet.

// File: rtl/csma_pkg.sv
package csma_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_TX      = 3'd1,
    ST_JAM     = 3'd2,
    ST_BACKOFF = 3'd3,
    ST_RETRY   = 3'd4
  } csma_state_e;

endpackage

// File: rtl/csma_lfsr.sv
module csma_lfsr #(
  parameter int          W     = 16,
  parameter logic [W-1:0] TAPS = 16'hB400,
  parameter logic [W-1:0] SEED = 16'hACE1,
  parameter int          OUT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [OUT_W-1:0] rnd_o
);

  logic [W-1:0] q_q, q_n;

  // Galois form, shifts right every cycle
  always_comb begin
    q_n = {1'b0, q_q[W-1:1]} ^ (q_q[0] ? TAPS : '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= SEED;
    else         q_q <= q_n;
  end

  assign rnd_o = q_q[OUT_W-1:0];

endmodule

// File: rtl/csma_sat_cnt.sv
module csma_sat_cnt #(
  parameter int LIMIT = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic full_o
);

  localparam int W = (LIMIT < 1) ? 1 : $clog2(LIMIT + 1);

  logic [W-1:0] cnt_q, cnt_n;
  logic         cnt_en;

  assign full_o = (cnt_q == W'(LIMIT));
  assign cnt_en = clr_i | (inc_i & ~full_o);

  always_comb begin
    cnt_n = clr_i ? '0 : cnt_q + W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_n;
  end

endmodule

// File: rtl/csma_backoff_calc.sv
module csma_backoff_calc #(
  parameter int LIMIT     = 10,
  parameter int SLOT_BITS = 512,
  parameter int ATT_W     = 5,
  parameter int CNT_W     = 20
) (
  input  logic [ATT_W-1:0] attempts_i,
  input  logic [LIMIT-1:0] rnd_i,
  output logic [CNT_W-1:0] load_o,
  output logic             zero_o
);

  logic [ATT_W-1:0] exp_w;
  logic [LIMIT-1:0] mask;
  logic [LIMIT-1:0] slots;
  logic [CNT_W-1:0] ticks;

  assign exp_w = (attempts_i > ATT_W'(LIMIT)) ? ATT_W'(LIMIT) : attempts_i;

  for (genvar i = 0; i < LIMIT; i++) begin : g_mask
    assign mask[i] = (exp_w > ATT_W'(i));
  end

  assign slots  = rnd_i & mask;
  assign ticks  = CNT_W'(slots) * CNT_W'(SLOT_BITS);
  assign load_o = ticks - CNT_W'(1);
  assign zero_o = (slots == '0);

endmodule

// File: rtl/csma_col_ctrl.sv
module csma_col_ctrl
  import csma_pkg::*;
#(
  parameter int          JAM_BITS      = 32,
  parameter int          SLOT_BITS     = 512,
  parameter int          MAX_ATTEMPTS  = 16,
  parameter int          BACKOFF_LIMIT = 10,
  parameter logic [15:0] LFSR_SEED     = 16'hACE1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_tick_i,
  input  logic col_i,
  input  logic tx_active_i,
  input  logic frame_start_i,
  output logic jam_o,
  output logic backoff_o,
  output logic retry_o,
  output logic late_col_o,
  output logic abort_o
);

  localparam int ATT_W = $clog2(MAX_ATTEMPTS + 1);
  localparam int CNT_W = BACKOFF_LIMIT + $clog2(SLOT_BITS) + 1;

  csma_state_e        state_q, state_n;
  logic [ATT_W-1:0]   att_q, att_n;
  logic [CNT_W-1:0]   bo_q, bo_n;
  logic               late_q, late_n;
  logic               abort_q, abort_n;

  logic               win_clr, win_full;
  logic               jam_clr, jam_full, jam_last;
  logic [BACKOFF_LIMIT-1:0] rnd;
  logic [CNT_W-1:0]   bo_load;
  logic               bo_zero;
  logic               col_hit;

  csma_lfsr #(
    .W(16), .TAPS(16'hB400), .SEED(LFSR_SEED), .OUT_W(BACKOFF_LIMIT)
  ) u_lfsr (
    .clk_i(clk_i), .rst_ni(rst_ni), .rnd_o(rnd)
  );

  // ticks since frame start, saturating at one slot
  csma_sat_cnt #(.LIMIT(SLOT_BITS)) u_win (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(win_clr),
    .inc_i(bit_tick_i & (state_q == ST_TX)), .full_o(win_full)
  );

  // ticks spent in the jam
  csma_sat_cnt #(.LIMIT(JAM_BITS - 1)) u_jam (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(jam_clr),
    .inc_i(bit_tick_i & (state_q == ST_JAM)), .full_o(jam_full)
  );

  csma_backoff_calc #(
    .LIMIT(BACKOFF_LIMIT), .SLOT_BITS(SLOT_BITS), .ATT_W(ATT_W), .CNT_W(CNT_W)
  ) u_calc (
    .attempts_i(att_q), .rnd_i(rnd), .load_o(bo_load), .zero_o(bo_zero)
  );

  assign col_hit  = col_i & tx_active_i;
  assign jam_last = jam_full & bit_tick_i;

  always_comb begin
    state_n = state_q;
    att_n   = att_q;
    bo_n    = bo_q;
    late_n  = late_q;
    abort_n = 1'b0;
    win_clr = 1'b0;
    jam_clr = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (frame_start_i) begin
          state_n = ST_TX;
          att_n   = '0;
          late_n  = 1'b0;
          win_clr = 1'b1;
        end
      end
      ST_RETRY: begin
        if (frame_start_i) begin
          state_n = ST_TX;
          late_n  = 1'b0;
          win_clr = 1'b1;
        end
      end
      ST_TX: begin
        if (col_hit) begin
          state_n = ST_JAM;
          jam_clr = 1'b1;
          if (win_full) late_n = 1'b1;
          else          att_n  = att_q + ATT_W'(1);
        end else if (!tx_active_i) begin
          state_n = ST_IDLE;
          att_n   = '0;
        end
      end
      ST_JAM: begin
        if (jam_last) begin
          if (late_q) begin
            state_n = ST_IDLE;
          end else if (att_q == ATT_W'(MAX_ATTEMPTS)) begin
            state_n = ST_IDLE;
            abort_n = 1'b1;
            att_n   = '0;
          end else if (bo_zero) begin
            state_n = ST_RETRY;
          end else begin
            state_n = ST_BACKOFF;
            bo_n    = bo_load;
          end
        end
      end
      ST_BACKOFF: begin
        if (bit_tick_i) begin
          if (bo_q == '0) state_n = ST_RETRY;
          else            bo_n    = bo_q - CNT_W'(1);
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      att_q   <= '0;
      bo_q    <= '0;
      late_q  <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      state_q <= state_n;
      att_q   <= att_n;
      bo_q    <= bo_n;
      late_q  <= late_n;
      abort_q <= abort_n;
    end
  end

  assign jam_o      = (state_q == ST_JAM);
  assign backoff_o  = (state_q == ST_BACKOFF);
  assign retry_o    = (state_q == ST_RETRY);
  assign late_col_o = late_q;
  assign abort_o    = abort_q;

endmodule

// File: rtl/csma_col_chk.sv
module csma_col_chk
  import csma_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic        col_i,
  input logic        tx_active_i,
  input logic        frame_start_i,
  input csma_state_e state_i,
  input logic        jam_o,
  input logic        backoff_o,
  input logic        retry_o,
  input logic        late_col_o,
  input logic        abort_o
);

  AST_COL_STARTS_JAM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_TX && col_i && tx_active_i) |=> jam_o); // R2

  AST_IDLE_NO_JAM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_IDLE) |=> !jam_o); // R3

  AST_LATE_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    late_col_o |-> (!backoff_o && !retry_o)); // R5

  AST_BACKOFF_AFTER_JAM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(backoff_o) |-> $past(jam_o)); // R6

  AST_ONE_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({jam_o, backoff_o, retry_o})); // R7

  AST_RETRY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (retry_o && !frame_start_i) |=> retry_o); // R7

  AST_ABORT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |=> !abort_o); // R8

  AST_ABORT_FROM_JAM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(abort_o) |-> $past(jam_o)); // R8

endmodule

bind csma_col_ctrl csma_col_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .col_i(col_i), .tx_active_i(tx_active_i),
  .frame_start_i(frame_start_i), .state_i(state_q), .jam_o(jam_o),
  .backoff_o(backoff_o), .retry_o(retry_o), .late_col_o(late_col_o),
  .abort_o(abort_o)
);

// File: tb/csma_col_ctrl_tb.sv
module csma_col_ctrl_tb;

  localparam int JB = 4;
  localparam int SB = 8;
  localparam int MA = 16;
  localparam int BL = 6;

  localparam int M_IDLE = 0, M_TX = 1, M_JAM = 2, M_BO = 3, M_RT = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic tick, col, act, fs;
  logic jam, bo, rt, late, abrt;

  always #10 clk = ~clk;

  csma_col_ctrl #(
    .JAM_BITS(JB), .SLOT_BITS(SB), .MAX_ATTEMPTS(MA), .BACKOFF_LIMIT(BL)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bit_tick_i(tick), .col_i(col),
    .tx_active_i(act), .frame_start_i(fs), .jam_o(jam), .backoff_o(bo),
    .retry_o(rt), .late_col_o(late), .abort_o(abrt)
  );

  int errors = 0;
  int checks = 0;
  int cyc_cnt = 0;
  int tper = 1;
  int tcnt = 0;

  // reference model state
  int  mode, att, win, jt, bt, bound;
  bit  m_late, exp_abort, armed;
  bit  p_tick, p_col, p_act, p_fs;
  logic [63:0] seen_r;

  task automatic chk(input bit ok, input string req, input string what,
                     input int actual, input int expected);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d (t=%0t)",
               req, what, actual, expected, $time);
    end
  endtask

  function automatic int min_i(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      mode = M_IDLE; att = 0; win = 0; jt = 0; bt = 0; bound = 0;
      m_late = 0; exp_abort = 0; armed = 0;
    end else begin
      if (!armed) armed = 1;
      else begin
        exp_abort = 0;
        case (mode)
          M_IDLE: if (p_fs) begin mode = M_TX; win = 0; m_late = 0; att = 0; end
          M_RT:   if (p_fs) begin mode = M_TX; win = 0; m_late = 0; end
          M_TX: begin
            if (p_col && p_act) begin
              if (win >= SB) m_late = 1; else att++;
              mode = M_JAM; jt = 0;
            end else if (!p_act) begin
              att = 0; mode = M_IDLE;
            end else if (p_tick && win < SB) win++;
          end
          M_JAM: if (p_tick) begin
            jt++;
            if (jt == JB) begin
              if (m_late) mode = M_IDLE;
              else if (att == MA) begin exp_abort = 1; att = 0; mode = M_IDLE; end
              else begin
                bound = (1 << min_i(att, BL)) - 1;
                if (bo) begin mode = M_BO; bt = 0; end
                else begin mode = M_RT; seen_r[0] = 1'b1; end
              end
            end
          end
          M_BO: begin
            if (p_tick) bt++;
            if (!bo) begin
              chk(bt > 0 && bt % SB == 0, "R6", "backoff ticks multiple of slot", bt, SB);
              chk(bt / SB <= bound, (att > BL) ? "R10" : "R6",
                  "backoff slots within bound", bt / SB, bound);
              if (bt / SB < 64) seen_r[bt / SB] = 1'b1;
              mode = M_RT;
            end
          end
          default: mode = M_IDLE;
        endcase
        chk(jam === (mode == M_JAM), "R2", "jam_o", int'(jam), int'(mode == M_JAM));
        chk(bo === (mode == M_BO), "R6", "backoff_o", int'(bo), int'(mode == M_BO));
        chk(rt === (mode == M_RT), "R7", "retry_o", int'(rt), int'(mode == M_RT));
        chk(late === m_late, "R5", "late_col_o", int'(late), int'(m_late));
        chk(abrt === exp_abort, "R8", "abort_o", int'(abrt), int'(exp_abort));
      end
    end
    p_tick = tick; p_col = col; p_act = act; p_fs = fs;
  end

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt >= 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d cycles", cyc_cnt, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic bit auto_tick();
    tcnt++;
    return (tcnt % tper) == 0;
  endfunction

  task automatic cyc(input bit t, input bit c, input bit a, input bit f);
    @(posedge clk);
    #2;
    tick = t; col = c; act = a; fs = f;
  endtask

  // start a frame, send nt ticks, then collide and run out jam and backoff
  task automatic frame_collide(input int nt);
    cyc(0, 0, 1, 1);
    for (int i = 0; i < nt; i++) cyc(1, 0, 1, 0);
    cyc(0, 1, 1, 0);
    cyc(auto_tick(), 0, 0, 0);
    while (jam || bo) cyc(auto_tick(), 0, 0, 0);
  endtask

  task automatic frame_success(input int nt);
    cyc(0, 0, 1, 1);
    for (int i = 0; i < nt; i++) cyc(1, 0, 1, 0);
    cyc(0, 0, 0, 0);
    cyc(0, 0, 0, 0);
  endtask

  initial begin
    seen_r = '0;
    tick = 0; col = 0; act = 0; fs = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #2;
    chk({jam, bo, rt, late, abrt} == 5'b0, "R1", "outputs in reset",
        int'({jam, bo, rt, late, abrt}), 0);
    rst_n = 1;
    @(negedge clk);
    chk({jam, bo, rt, late, abrt} == 5'b0, "R1", "outputs after release",
        int'({jam, bo, rt, late, abrt}), 0);

    // R3: collision while idle, and with tx_active low in transmit phase
    for (int i = 0; i < 5; i++) cyc(1, 1, 0, 0);
    cyc(0, 0, 1, 1);
    cyc(1, 1, 0, 0);
    cyc(0, 0, 0, 0);
    cyc(0, 0, 0, 0);
    chk(jam == 0 && bo == 0 && rt == 0, "R3", "collision ignored", int'(jam), 0);

    frame_success(5);

    // R4 boundary: one tick short of the slot is early
    frame_collide(SB - 1);
    chk(late == 0 && rt == 1, "R4", "collision before window end is early",
        int'(late), 0);
    // R4/R5: exactly one slot of ticks is late
    frame_collide(SB);
    chk(late == 1, "R4", "collision at window end is late", int'(late), 1);
    chk(rt == 0 && bo == 0, "R5", "no retry after late collision", int'(rt), 0);
    for (int i = 0; i < 6; i++) cyc(1, 0, 0, 0);
    chk(late == 1, "R5", "late flag held while idle", int'(late), 1);

    // R2: jam under sparse ticks
    tper = 3;
    frame_collide(1);
    chk(late == 0, "R5", "late flag cleared by frame start", int'(late), 0);
    tper = 1;
    frame_success(2);

    // R8: sixteen consecutive early collisions
    for (int i = 1; i <= MA; i++) begin
      frame_collide(2);
      if (i < MA) chk(rt == 1 && abrt == 0, "R7", "retry after early collision",
                      int'(rt), 1);
      else        chk(abrt == 1 && rt == 0, "R8", "abort on last attempt",
                      int'(abrt), 1);
    end
    cyc(0, 0, 0, 0);
    chk(abrt == 0, "R8", "abort lasts one cycle", int'(abrt), 0);

    // R9: success clears the count
    for (int i = 1; i < MA; i++) frame_collide(2);
    frame_success(3);
    frame_collide(2);
    chk(rt == 1 && abrt == 0, "R9", "count cleared by success", int'(abrt), 0);

    // R9: fresh frame from idle clears the count
    for (int i = 2; i < MA; i++) frame_collide(2);
    frame_collide(SB + 1);
    chk(late == 1 && rt == 0, "R5", "late collision after retries", int'(late), 1);
    frame_collide(2);
    chk(rt == 1 && abrt == 0, "R9", "count cleared by new frame", int'(abrt), 0);

    chk($countones(seen_r) >= 2, "R11", "distinct backoff slot counts",
        $countones(seen_r), 2);

    cyc(0, 0, 0, 0);
    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule